// File: doc/BRIEF.md
# Packed Single-Precision NaN Propagation Unit

This block sits at the output of a four-lane packed single-precision arithmetic datapath. Each lane receives two source operands, the result that the datapath computed, and a flag saying whether the operation was invalid. The unit sorts every operand into one of four classes: signaling NaN, quiet NaN, infinity or ordinary value. It then decides what each lane delivers. NaN sources are forwarded with the quiet bit forced on. An invalid operation that has no NaN input produces the default indefinite QNaN. All other lanes pass the datapath result through untouched.

A single mask bit controls what happens on an invalid operation. With the mask set, the quietened or default value is written and a sticky invalid flag is raised. With the mask clear, the whole destination is left unwritten and a one-cycle fault pulse is produced instead. The sticky flag stays set until a dedicated clear input is applied. Every output is registered, so results appear one clock after the operation is presented.

Top module: `nanprop_unit`

## Requirements
- R1: An operand with an all-ones exponent and a zero fraction is an infinity and is not treated as a NaN: the lane delivers the arithmetic result unchanged (for example 0x7F800000 as a source passes the arithmetic result).
- R2: A quiet NaN source (exponent all ones, fraction bit 22 set) is delivered with its sign and payload bits unchanged, raises neither the sticky flag nor a fault, and is written even when the mask is clear.
- R3: With the mask set, a signaling NaN source (exponent all ones, bit 22 clear, bits 21:0 non-zero) is delivered with bit 22 forced to 1 and all other bits, including the sign, preserved. The lane is written and the sticky flag is set.
- R4: Whenever a lane has a NaN source, the delivered value has fraction bit 22 set.
- R5: When both sources of a lane are NaN, the quietened first source (A) is delivered. When only one is a NaN, that one is delivered.
- R6: With the mask set, a lane whose arithmetic-invalid flag is high and whose sources are not NaN delivers 0xFFC00000 and sets the sticky flag.
- R7: With the mask clear, if any lane is invalid (a signaling NaN source, or the arithmetic-invalid flag with no NaN source), the write enable stays low and all four result lanes keep their previous contents.
- R8: The fault output is high for exactly the one cycle that follows an operation containing an unmasked invalid lane, and is low otherwise.
- R9: The sticky flag stays set until the clear input is applied. If the flag is set and cleared in the same cycle, the set wins.
- R10: A lane with no NaN source and no arithmetic-invalid flag delivers the arithmetic result bit-for-bit. When a NaN source is present, the arithmetic-invalid flag is ignored.
- R11: Outputs are registered one cycle after the operation-valid input. A cycle without an operation leaves the write enable low and the results unchanged. Reset clears the results, the write enable, the flag and the fault to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| src_a | input | LANES*32 | First source operand, lane 0 in the low bits |
| src_b | input | LANES*32 | Second source operand |
| arith_res | input | LANES*32 | Result computed by the arithmetic datapath |
| arith_inv | input | LANES | Per-lane invalid indication from the datapath |
| inv_mask | input | 1 | Invalid-operation mask: 1 means write a value and flag it, 0 means raise a fault |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| res_data | output | LANES*32 | Registered result lanes |
| res_we | output | 1 | Destination write enable |
| inv_sticky | output | 1 | Sticky invalid flag |
| fault | output | 1 | One-cycle unmasked-invalid fault pulse |

## Verification
The bench builds the unit with its default parameters: four lanes of 8-bit exponent and 23-bit fraction. This allows stimulus mixing lane classes across all four lanes in one operation. Exact single-precision encodings such as 0x7F800001, 0xFF812345 and 0xFFC00000 are then within reach, including the boundary between a signaling NaN and an infinity. A behavioural model is compared on every clock. The stimulus covers back-to-back masked and unmasked operations, idle cycles, and a flag set and clear in the same cycle.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        CLS_ORD  = 2'd0,
        CLS_INF  = 2'd1,
        CLS_QNAN = 2'd2,
        CLS_SNAN = 2'd3
    } fp_class_e;

    typedef struct packed {
        word_t value;
        logic  invalid;
    } lane_out_t;

    // Indefinite: sign set, exponent all ones, only the quiet bit set.
    localparam word_t INDEF_QNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic fp_class_e classify(input word_t w);
        logic exp_ones;
        exp_ones = &w[WORD_W-2:FRAC_W];
        if (!exp_ones)                 return CLS_ORD;
        if (w[FRAC_W-1:0] == '0)       return CLS_INF;
        if (w[QBIT])                   return CLS_QNAN;
        return CLS_SNAN;
    endfunction

    function automatic word_t quieten(input word_t w);
        word_t q;
        q = w;
        q[QBIT] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
    import nanprop_pkg::*;
(
    input  word_t     operand,
    output fp_class_e cls,
    output logic      is_nan
);
    always_comb begin
        cls    = classify(operand);
        is_nan = (cls == CLS_QNAN) || (cls == CLS_SNAN);
    end
endmodule

// File: rtl/nanprop_lane.sv
module nanprop_lane
    import nanprop_pkg::*;
(
    input  word_t     op_a,
    input  word_t     op_b,
    input  word_t     arith_val,
    input  logic      arith_bad,
    output lane_out_t lane_out
);
    fp_class_e cls_a, cls_b;
    logic      nan_a, nan_b;

    nanprop_classify u_cls_a (.operand(op_a), .cls(cls_a), .is_nan(nan_a));
    nanprop_classify u_cls_b (.operand(op_b), .cls(cls_b), .is_nan(nan_b));

    always_comb begin
        if (nan_a) begin
            lane_out.value   = quieten(op_a);
            lane_out.invalid = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
        end else if (nan_b) begin
            lane_out.value   = quieten(op_b);
            lane_out.invalid = (cls_b == CLS_SNAN);
        end else if (arith_bad) begin
            lane_out.value   = INDEF_QNAN;
            lane_out.invalid = 1'b1;
        end else begin
            lane_out.value   = arith_val;
            lane_out.invalid = 1'b0;
        end
    end

    // R4: a NaN input always leaves with the quiet bit on
    always_comb begin
        if (nan_a || nan_b) begin
            p_nan_quiet_r4: assert (lane_out.value[QBIT] == 1'b1);
        end
    end
endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
    import nanprop_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_valid,
    input  logic [LANES*WORD_W-1:0] src_a,
    input  logic [LANES*WORD_W-1:0] src_b,
    input  logic [LANES*WORD_W-1:0] arith_res,
    input  logic [LANES-1:0]        arith_inv,
    input  logic                    inv_mask,
    input  logic                    flag_clr,
    output logic [LANES*WORD_W-1:0] res_data,
    output logic                    res_we,
    output logic                    inv_sticky,
    output logic                    fault
);
    lane_out_t                 lane_q [LANES];
    logic [LANES-1:0]          lane_bad;
    logic [LANES*WORD_W-1:0]   next_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nanprop_lane u_lane (
            .op_a      (src_a[g*WORD_W +: WORD_W]),
            .op_b      (src_b[g*WORD_W +: WORD_W]),
            .arith_val (arith_res[g*WORD_W +: WORD_W]),
            .arith_bad (arith_inv[g]),
            .lane_out  (lane_q[g])
        );
        assign lane_bad[g]                  = lane_q[g].invalid;
        assign next_data[g*WORD_W +: WORD_W] = lane_q[g].value;
    end

    logic any_bad, trap, commit, set_flag;
    always_comb begin
        any_bad  = |lane_bad;
        trap     = op_valid && any_bad && !inv_mask;
        commit   = op_valid && !(any_bad && !inv_mask);
        set_flag = op_valid && any_bad && inv_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data   <= '0;
            res_we     <= 1'b0;
            inv_sticky <= 1'b0;
            fault      <= 1'b0;
        end else begin
            res_we <= commit;
            fault  <= trap;
            if (commit)        res_data   <= next_data;
            if (set_flag)      inv_sticky <= 1'b1;
            else if (flag_clr) inv_sticky <= 1'b0;
        end
    end

    p_fault_blocks_write_r7: assert property (@(posedge clk) disable iff (rst)
        fault |-> !res_we);
    p_fault_keeps_data_r7: assert property (@(posedge clk) disable iff (rst)
        fault |-> $stable(res_data));
    p_sticky_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (inv_sticky && !flag_clr) |=> inv_sticky);
    p_we_after_valid_r11: assert property (@(posedge clk) disable iff (rst)
        res_we |-> $past(op_valid));
    p_fault_after_valid_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(op_valid && !inv_mask));
endmodule

// File: tb/nanprop_unit_tb_top.sv
`timescale 1ns/1ps
module nanprop_unit_tb_top;
    localparam int L = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          op_valid = 0, inv_mask = 0, flag_clr = 0;
    logic [L*32-1:0] src_a = '0, src_b = '0, arith_res = '0;
    logic [L-1:0]  arith_inv = '0;
    logic [L*32-1:0] res_data;
    logic          res_we, inv_sticky, fault;

    nanprop_unit #(.LANES(L)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .src_a(src_a), .src_b(src_b),
        .arith_res(arith_res), .arith_inv(arith_inv), .inv_mask(inv_mask),
        .flag_clr(flag_clr), .res_data(res_data), .res_we(res_we),
        .inv_sticky(inv_sticky), .fault(fault)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [31:0] a [L], b [L], r [L];
    logic [L*32-1:0] m_data = '0;
    logic m_we = 0, m_flag = 0, m_fault = 0;

    function automatic bit is_nan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [31:0] w);
        return is_nan(w) && !w[22];
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [L*32-1:0] act, input logic [L*32-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit valid, input bit mask, input bit clr, input string tag);
        logic [L*32-1:0] nd;
        bit bad;
        bad = 0;
        nd  = '0;
        for (int i = 0; i < L; i++) begin
            logic [31:0] v;
            if (is_nan(a[i]))      begin v = a[i] | 32'h0040_0000; bad |= is_snan(a[i]) || is_snan(b[i]); end
            else if (is_nan(b[i])) begin v = b[i] | 32'h0040_0000; bad |= is_snan(b[i]); end
            else if (arith_inv[i]) begin v = 32'hFFC0_0000; bad = 1; end
            else                    v = r[i];
            nd[i*32 +: 32] = v;
            src_a[i*32 +: 32]     = a[i];
            src_b[i*32 +: 32]     = b[i];
            arith_res[i*32 +: 32] = r[i];
        end
        op_valid = valid; inv_mask = mask; flag_clr = clr;
        m_fault = valid && bad && !mask;
        m_we    = valid && !(bad && !mask);
        if (m_we) m_data = nd;
        if (valid && bad && mask) m_flag = 1;
        else if (clr)             m_flag = 0;
        @(negedge clk);
        cmp(tag, "res_data", res_data, m_data);
        cmp(tag, "res_we", {{(L*32-1){1'b0}}, res_we}, {{(L*32-1){1'b0}}, m_we});
        cmp(tag, "inv_sticky", {{(L*32-1){1'b0}}, inv_sticky}, {{(L*32-1){1'b0}}, m_flag});
        cmp(tag, "fault", {{(L*32-1){1'b0}}, fault}, {{(L*32-1){1'b0}}, m_fault});
        op_valid = 0; flag_clr = 0; arith_inv = '0;
    endtask

    task automatic fill_ord();
        for (int i = 0; i < L; i++) begin
            a[i] = 32'h3F80_0000 + i; b[i] = 32'h4000_0000 + i; r[i] = 32'h4040_0000 + 16*i;
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        fill_ord();
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        // R11: reset state
        cmp("R11", "reset res_data", res_data, '0);
        cmp("R11", "reset flags", {res_we, inv_sticky, fault}, '0);

        fill_ord(); step(1, 0, 0, "R10");          // ordinary lanes pass through
        fill_ord(); r[3] = 32'h7F80_0001; step(1, 0, 0, "R10"); // datapath SNaN untouched
        fill_ord(); a[1] = 32'h7F80_0000; b[2] = 32'hFF80_0000; step(1, 0, 0, "R1");
        fill_ord(); b[0] = 32'h7FC1_2345; a[3] = 32'hFFE0_0F0F; step(1, 0, 0, "R2");
        fill_ord(); a[2] = 32'h7FC0_0001; arith_inv = 4'b0100; step(1, 0, 0, "R10");
        step(0, 0, 0, "R11");                       // idle keeps data
        fill_ord(); a[0] = 32'h7F80_0001; b[1] = 32'hFF81_2345; step(1, 1, 0, "R3");
        step(0, 0, 1, "R9");                        // clear
        fill_ord(); a[2] = 32'h7FC0_AAAA; b[2] = 32'h7F80_BBBB;
                    a[3] = 32'hFFA0_0001; b[3] = 32'h7FC0_0002; step(1, 1, 0, "R5");
        fill_ord(); a[1] = 32'h7FC0_1111; b[1] = 32'hFFC0_2222; step(1, 1, 1, "R5");
        step(0, 0, 0, "R9");                        // flag holds
        fill_ord(); arith_inv = 4'b1001; step(1, 1, 1, "R6"); // set beats clear
        step(0, 0, 1, "R9");
        fill_ord(); b[3] = 32'h7F80_0010; step(1, 0, 0, "R7");
        step(0, 0, 0, "R8");                        // fault drops
        fill_ord(); arith_inv = 4'b0010; step(1, 0, 0, "R7");
        fill_ord(); arith_inv = 4'b0010; step(1, 0, 0, "R8"); // back-to-back fault
        fill_ord(); a[0] = 32'h7F80_0000; b[0] = 32'h7F80_0002; step(1, 1, 0, "R4");
        fill_ord(); step(1, 0, 0, "R10");
        step(0, 0, 1, "R11");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule